// File: doc/BRIEF.md
# NIC Interrupt Cause and Moderation Unit

This unit gathers interrupt causes raised by the receive and transmit engines of a network controller into a pending-cause register. It gates those causes with a mask and drives one level-sensitive interrupt line toward the host. Software reads the pending register to learn why it was interrupted. The read also clears the register and drops the line.

Four delay timers defer receive and transmit notifications: a per-packet delay and an absolute delay for each direction. When one of them runs out, the unit asks that direction's descriptor engine for a complete writeback of all used descriptors, with no alignment restriction. One cycle later it posts the matching cause. A minimum-spacing limiter keeps successive rising edges of the line apart by a programmable number of time units. One unit lasts `UNIT_CYCLES` clock cycles, which is 1024 ns at the intended clock. A post flagged as immediate skips the limiter.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset, the interrupt line is low, the pending register reads 0, the mask is all zeros (every cause masked) and neither writeback request is asserted.
- R2: A post with `postValid` ORs `postCause` into the pending register at the next clock edge, and `rdData` shows the result. A cause whose mask bit is 0 never raises the line.
- R3: When the limiter is idle, the line rises one clock after an unmasked pending bit becomes visible. The line stays high while any unmasked cause is pending and no read happens.
- R4: `rdStb` clears the pending register and lowers the line at the next edge. `rdData` holds the pre-clear value during the strobe cycle. A cause posted in the same cycle as the read survives the clear.
- R5: A mask write takes effect at the next edge. The line rises one clock later if a newly unmasked cause is pending, and drops one clock later if no unmasked cause remains.
- R6: Timer 0 (receive per-packet) and timer 1 (receive absolute) each expire interval x `UNIT_CYCLES` clocks after the edge that starts them. The interval is field i of `tmrInterval`, at bits [i*TMR_W +: TMR_W]. On expiry, `wbReqRx` pulses for one cycle, and pending bit 7 (receive timer) is set at the following edge.
- R7: Timer 2 (transmit interrupt delay) and timer 3 (transmit absolute) expire in the same way. On expiry, `wbReqTx` pulses for one cycle, and pending bit 0 (transmit descriptors written back) is set at the following edge.
- R8: A `txWbDone` pulse sets pending bit 0 at the next edge.
- R9: A start strobe on a running timer keeps its existing deadline. A restart strobe reloads the timer from its interval field at that edge.
- R10: A timer whose interval field is 0 ignores both start and restart and never expires.
- R11: Each rising edge of the line starts the limiter for `limitInterval` units. A non-immediate rising edge cannot occur until the clock after the limiter expires. A rising edge held back this way is made then, if an unmasked cause is still pending.
- R12: A post with `postNow` set lets the line rise one clock after the cause is visible, even while the limiter is running.
- R13: A `limitInterval` of 0 places no spacing between rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| postValid | input | 1 | Post the causes on `postCause` |
| postCause | input | 8 | Cause bits to set in the pending register |
| postNow | input | 1 | Immediate flag: the post bypasses the limiter |
| txWbDone | input | 1 | A transmit descriptor writeback has completed |
| tmrStart | input | 4 | Start strobe per timer (ignored while that timer runs) |
| tmrRestart | input | 4 | Restart strobe per timer (always reloads) |
| tmrInterval | input | 4*TMR_W | Interval of each timer, in units |
| limitInterval | input | LIM_W | Minimum spacing between rising edges, in units |
| maskWrEn | input | 1 | Write the mask register |
| maskWrData | input | 8 | New mask value (1 enables a cause) |
| rdStb | input | 1 | Read strobe for the pending register (clears it) |
| rdData | output | 8 | Pending-cause register value |
| irqLine | output | 1 | Interrupt line to the host |
| wbReqRx | output | 1 | Request a full receive descriptor writeback |
| wbReqTx | output | 1 | Request a full transmit descriptor writeback |

## Verification
The hardest situation to reach is a rising edge that the limiter has deferred. The line must first rise and start the limiter. Then a read must clear it, and a new non-immediate cause must arrive while the limiter is still counting. The bench sets up that sequence with a short unit length and checks that the deferred edge lands on the exact clock after the limiter expires. It then replays the same sequence with the immediate flag and again with a zero interval, and checks that in both cases the edge comes early. Deadline retention is reached by sending a second start strobe to a timer in the middle of its count, and comparing the expiry cycle with the cycle that a restart strobe produces.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CAUSE_W = 8;
  localparam int NUM_TMR = 4;
  // timer slots
  localparam int TMR_RX_PKT = 0;
  localparam int TMR_RX_ABS = 1;
  localparam int TMR_TX_INT = 2;
  localparam int TMR_TX_ABS = 3;
  // cause bit positions
  localparam int CAUSE_TXWB  = 0;
  localparam int CAUSE_RXTMR = 7;

  typedef struct packed {
    logic               clrPend;
    logic [CAUSE_W-1:0] setVec;
  } irqStrb_t;
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W       = 8,
  parameter int UNIT_CYCLES = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             restart,
  input  logic [CNT_W-1:0] interval,
  output logic             busy,
  output logic             expire
);
  localparam int SUB_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(UNIT_CYCLES - 1);

  logic [SUB_W-1:0] subCnt;
  logic [CNT_W-1:0] unitCnt;
  logic             runQ;
  logic             expQ;
  logic             load;

  // a zero interval disables the timer; start only arms an idle timer
  assign load = (interval != '0) && (restart || (start && !runQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt  <= '0;
      unitCnt <= '0;
      runQ    <= 1'b0;
      expQ    <= 1'b0;
    end else begin
      expQ <= 1'b0;
      if (load) begin
        runQ    <= 1'b1;
        unitCnt <= interval;
        subCnt  <= SUB_TOP;
      end else if (runQ) begin
        if (subCnt == '0) begin
          subCnt <= SUB_TOP;
          if (unitCnt == CNT_W'(1)) begin
            runQ <= 1'b0;
            expQ <= 1'b1;
          end else begin
            unitCnt <= unitCnt - CNT_W'(1);
          end
        end else begin
          subCnt <= subCnt - SUB_W'(1);
        end
      end
    end
  end

  assign busy   = runQ;
  assign expire = expQ;

  // R9: a repeated start on a running timer leaves the unit count alone
  a_r9_keep_deadline: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && start && !restart && subCnt != '0) |=> $stable(unitCnt));

  // R10: a zero interval never arms the timer
  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && interval == '0) |=> !runQ);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrb_t           strb,
  input  logic               maskWrEn,
  input  logic [CAUSE_W-1:0] maskWrData,
  output logic [CAUSE_W-1:0] pending,
  output logic               anyActive
);
  logic [CAUSE_W-1:0] pendQ;
  logic [CAUSE_W-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
    end else begin
      // a same-cycle post wins over the read clear
      pendQ <= (strb.clrPend ? '0 : pendQ) | strb.setVec;
      if (maskWrEn) maskQ <= maskWrData;
    end
  end

  assign pending   = pendQ;
  assign anyActive = |(pendQ & maskQ);

  // R2: posted bits are present after the edge
  a_r2_bits_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec != '0) |=> ((pendQ & $past(strb.setVec)) == $past(strb.setVec)));

  // R2: with no post and no read, pending does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrPend && strb.setVec == '0) |=> $stable(pendQ));

  // R4: a read with nothing posted empties the register
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && strb.setVec == '0) |=> (pendQ == '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int LIM_W       = 8,
  parameter int UNIT_CYCLES = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     postValid,
  input  logic [CAUSE_W-1:0]       postCause,
  input  logic                     postNow,
  input  logic                     txWbDone,
  input  logic [NUM_TMR-1:0]       tmrStart,
  input  logic [NUM_TMR-1:0]       tmrRestart,
  input  logic [NUM_TMR*TMR_W-1:0] tmrInterval,
  input  logic [LIM_W-1:0]         limitInterval,
  input  logic                     rdStb,
  input  logic                     anyActive,
  output irqStrb_t                 strb,
  output logic                     wbReqRx,
  output logic                     wbReqTx,
  output logic                     irqLine
);
  logic [NUM_TMR-1:0] tmrRun;
  logic [NUM_TMR-1:0] tmrExp;
  logic limBusy, limExp;
  logic lineQ, immHold, raise;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    irq_timer #(.CNT_W(TMR_W), .UNIT_CYCLES(UNIT_CYCLES)) u_tmr (
      .clk      (clk),
      .rstN     (rstN),
      .start    (tmrStart[i]),
      .restart  (tmrRestart[i]),
      .interval (tmrInterval[i*TMR_W +: TMR_W]),
      .busy     (tmrRun[i]),
      .expire   (tmrExp[i])
    );

    // R6/R7: an expiry pulse follows a running cycle
    a_r6_exp_after_run: assert property (@(posedge clk) disable iff (!rstN)
      tmrExp[i] |-> $past(tmrRun[i]));
  end

  assign wbReqRx = tmrExp[TMR_RX_PKT] | tmrExp[TMR_RX_ABS];
  assign wbReqTx = tmrExp[TMR_TX_INT] | tmrExp[TMR_TX_ABS];

  always_comb begin
    strb.clrPend = rdStb;
    strb.setVec  = postValid ? postCause : '0;
    if (wbReqTx || txWbDone) strb.setVec[CAUSE_TXWB] = 1'b1;
    if (wbReqRx)             strb.setVec[CAUSE_RXTMR] = 1'b1;
  end

  // spacing limiter, rearmed on every rising edge of the line
  irq_timer #(.CNT_W(LIM_W), .UNIT_CYCLES(UNIT_CYCLES)) u_limit (
    .clk      (clk),
    .rstN     (rstN),
    .start    (1'b0),
    .restart  (raise),
    .interval (limitInterval),
    .busy     (limBusy),
    .expire   (limExp)
  );

  assign raise = !lineQ && anyActive && !rdStb && (immHold || !limBusy);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ   <= 1'b0;
      immHold <= 1'b0;
    end else begin
      if (rdStb || !anyActive) lineQ <= 1'b0;
      else if (raise)          lineQ <= 1'b1;
      if (rdStb || raise)      immHold <= 1'b0;
      if (postValid && postNow) immHold <= 1'b1;
    end
  end

  assign irqLine = lineQ;

  // R3: the line is only high with an unmasked cause pending
  a_r3_line_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    lineQ |-> $past(anyActive));

  // R4: a read drops the line
  a_r4_read_drops: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> !lineQ);

  // R11/R12: a rising edge needs an idle limiter or an immediate post
  a_r11_spacing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineQ) |-> ($past(immHold) || !$past(limBusy)));

  // R11: the limiter expires only after running
  a_r11_lim_exp: assert property (@(posedge clk) disable iff (!rstN)
    limExp |-> $past(limBusy));
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
  import irq_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int LIM_W       = 8,
  parameter int UNIT_CYCLES = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     postValid,
  input  logic [CAUSE_W-1:0]       postCause,
  input  logic                     postNow,
  input  logic                     txWbDone,
  input  logic [NUM_TMR-1:0]       tmrStart,
  input  logic [NUM_TMR-1:0]       tmrRestart,
  input  logic [NUM_TMR*TMR_W-1:0] tmrInterval,
  input  logic [LIM_W-1:0]         limitInterval,
  input  logic                     maskWrEn,
  input  logic [CAUSE_W-1:0]       maskWrData,
  input  logic                     rdStb,
  output logic [CAUSE_W-1:0]       rdData,
  output logic                     irqLine,
  output logic                     wbReqRx,
  output logic                     wbReqTx
);
  irqStrb_t strb;
  logic     anyActive;

  irq_ctrl #(.TMR_W(TMR_W), .LIM_W(LIM_W), .UNIT_CYCLES(UNIT_CYCLES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .postValid     (postValid),
    .postCause     (postCause),
    .postNow       (postNow),
    .txWbDone      (txWbDone),
    .tmrStart      (tmrStart),
    .tmrRestart    (tmrRestart),
    .tmrInterval   (tmrInterval),
    .limitInterval (limitInterval),
    .rdStb         (rdStb),
    .anyActive     (anyActive),
    .strb          (strb),
    .wbReqRx       (wbReqRx),
    .wbReqTx       (wbReqTx),
    .irqLine       (irqLine)
  );

  irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .pending    (rdData),
    .anyActive  (anyActive)
  );
endmodule

// File: tb/nic_irq_moderator_bench.sv
module nic_irq_moderator_bench;
  localparam int TW = 8;
  localparam int LW = 8;
  localparam int U  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic postValid = 1'b0;
  logic [7:0] postCause = '0;
  logic postNow = 1'b0;
  logic txWbDone = 1'b0;
  logic [3:0] tmrStart = '0;
  logic [3:0] tmrRestart = '0;
  logic [4*TW-1:0] tmrInterval = '0;
  logic [LW-1:0] limitInterval = '0;
  logic maskWrEn = 1'b0;
  logic [7:0] maskWrData = '0;
  logic rdStb = 1'b0;
  logic [7:0] rdData;
  logic irqLine, wbReqRx, wbReqTx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nic_irq_moderator #(.TMR_W(TW), .LIM_W(LW), .UNIT_CYCLES(U)) u_nic_irq_moderator (
    .clk(clk), .rstN(rstN), .postValid(postValid), .postCause(postCause),
    .postNow(postNow), .txWbDone(txWbDone), .tmrStart(tmrStart),
    .tmrRestart(tmrRestart), .tmrInterval(tmrInterval),
    .limitInterval(limitInterval), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .rdStb(rdStb), .rdData(rdData), .irqLine(irqLine),
    .wbReqRx(wbReqRx), .wbReqTx(wbReqTx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic post(input logic [7:0] c, input logic now);
    postValid = 1'b1; postCause = c; postNow = now;
    tick(1);
    postValid = 1'b0; postCause = '0; postNow = 1'b0;
  endtask

  task automatic rd_clear();
    rdStb = 1'b1;
    tick(1);
    rdStb = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    maskWrEn = 1'b1; maskWrData = m;
    tick(1);
    maskWrEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 line", irqLine, 0);
    chk("R1 pending", rdData, 0);
    chk("R1 wbReqRx", wbReqRx, 0);
    chk("R1 wbReqTx", wbReqTx, 0);
    post(8'h01, 1'b0);
    tick(2);
    chk("R1 mask all off", irqLine, 0);
    rd_clear();
  endtask

  task automatic t_masked_post();
    post(8'h24, 1'b0);
    chk("R2 pending", rdData, 8'h24);
    tick(2);
    chk("R2 masked no line", irqLine, 0);
    rd_clear();
    chk("R4 cleared", rdData, 0);
  endtask

  task automatic t_unmasked();
    set_mask(8'hFF);
    post(8'h02, 1'b0);
    chk("R3 not yet", irqLine, 0);
    tick(1);
    chk("R3 line up", irqLine, 1);
    tick(3);
    chk("R3 line holds", irqLine, 1);
    chk("R4 read value", rdData, 8'h02);
    rd_clear();
    chk("R4 line down", irqLine, 0);
    chk("R4 pending zero", rdData, 0);
  endtask

  task automatic t_read_and_post();
    post(8'h01, 1'b0);
    tick(1);
    rdStb = 1'b1; postValid = 1'b1; postCause = 8'h10;
    tick(1);
    rdStb = 1'b0; postValid = 1'b0; postCause = '0;
    chk("R4 post survives", rdData, 8'h10);
    chk("R4 line dropped", irqLine, 0);
    tick(1);
    chk("R4 line again", irqLine, 1);
    rd_clear();
  endtask

  task automatic t_mask_reeval();
    set_mask(8'h00);
    post(8'h04, 1'b0);
    tick(2);
    chk("R5 masked", irqLine, 0);
    set_mask(8'h04);
    chk("R5 not yet", irqLine, 0);
    tick(1);
    chk("R5 unmask raises", irqLine, 1);
    set_mask(8'h00);
    chk("R5 still up", irqLine, 1);
    tick(1);
    chk("R5 mask drops", irqLine, 0);
    rd_clear();
    set_mask(8'hFF);
  endtask

  // Strobe timer idx at N0; optionally strobe again at N againAt.
  // Returns the negedge index at which the request is first seen.
  task automatic timer_probe(input int idx, input logic [7:0] ival,
                             input int againAt, input logic useRestart,
                             output int firstN, output int pulses);
    tmrInterval[idx*TW +: TW] = ival;
    firstN = 0; pulses = 0;
    tmrStart[idx] = 1'b1;
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      tmrStart = '0; tmrRestart = '0;
      if (n == againAt) begin
        if (useRestart) tmrRestart[idx] = 1'b1;
        else            tmrStart[idx] = 1'b1;
      end
      if ((idx < 2 ? wbReqRx : wbReqTx) === 1'b1) begin
        pulses++;
        if (firstN == 0) firstN = n;
      end
    end
    tmrStart = '0; tmrRestart = '0;
  endtask

  task automatic t_rx_timer();
    int f, p;
    tmrInterval[0 +: TW] = 8'd3;
    tmrStart[0] = 1'b1;
    tick(1);
    tmrStart = '0;
    tick(3*U - 1);
    chk("R6 early", wbReqRx, 0);
    tick(1);
    chk("R6 request", wbReqRx, 1);
    chk("R6 cause after request", rdData[7], 0);
    tick(1);
    chk("R6 pulse width", wbReqRx, 0);
    chk("R6 cause set", rdData, 8'h80);
    tick(1);
    chk("R6 line", irqLine, 1);
    rd_clear();
    timer_probe(1, 8'd2, 0, 1'b0, f, p);
    chk("R6 absolute timer time", f, 2*U + 1);
    chk("R6 single pulse", p, 1);
    chk("R6 absolute cause", rdData, 8'h80);
    rd_clear();
  endtask

  task automatic t_tx_timer();
    int f, p;
    timer_probe(2, 8'd3, 0, 1'b0, f, p);
    chk("R7 tx delay time", f, 3*U + 1);
    chk("R7 tx cause", rdData, 8'h01);
    rd_clear();
    timer_probe(3, 8'd5, 0, 1'b0, f, p);
    chk("R7 tx absolute time", f, 5*U + 1);
    chk("R7 tx pulse", p, 1);
    chk("R7 rx untouched", wbReqRx, 0);
    rd_clear();
  endtask

  task automatic t_txwb();
    txWbDone = 1'b1;
    tick(1);
    txWbDone = 1'b0;
    chk("R8 wb done cause", rdData, 8'h01);
    tick(1);
    chk("R8 line", irqLine, 1);
    rd_clear();
  endtask

  task automatic t_keep_restart();
    int f, p;
    timer_probe(1, 8'd4, 6, 1'b0, f, p);
    chk("R9 start keeps deadline", f, 4*U + 1);
    chk("R9 one expiry", p, 1);
    rd_clear();
    timer_probe(0, 8'd4, 6, 1'b1, f, p);
    chk("R9 restart reloads", f, 6 + 4*U + 1);
    chk("R9 one expiry after restart", p, 1);
    rd_clear();
  endtask

  task automatic t_zero();
    int f, p;
    timer_probe(2, 8'd0, 5, 1'b1, f, p);
    chk("R10 no expiry", p, 0);
    chk("R10 no cause", rdData, 0);
    chk("R10 line low", irqLine, 0);
  endtask

  // first negedge index (counted from the first post) at which the line is high
  task automatic limit_seq(input logic now2, output int firstN);
    firstN = 0;
    post(8'h01, 1'b0);     // N1 pending
    tick(1);               // N2 line up
    chk("R11 first edge", irqLine, 1);
    rd_clear();            // N3
    post(8'h02, now2);     // N4 pending
    for (int n = 4; n <= 40; n++) begin
      if (irqLine === 1'b1 && firstN == 0) firstN = n;
      tick(1);
    end
    rd_clear();
    tick(4*U);
  endtask

  task automatic t_limits();
    int f;
    limitInterval = 8'd3;
    limit_seq(1'b0, f);
    chk("R11 deferred edge", f, 3*U + 3);
    limit_seq(1'b1, f);
    chk("R12 immediate bypass", f, 5);
    limitInterval = 8'd0;
    tick(4*U);
    limit_seq(1'b0, f);
    chk("R13 no spacing", f, 5);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_masked_post();
    t_unmasked();
    t_read_and_post();
    t_mask_reeval();
    t_rx_timer();
    t_tx_timer();
    t_txwb();
    t_keep_restart();
    t_zero();
    t_limits();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-all: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule